// File: doc/BRIEF.md
# SMRAM Control and Address Decoder

This block holds an 8-bit control register for extended system-management memory and the address decoder that the register steers. Software reads and writes the register through a plain write-enable/data port, and the read data is always presented. A global SMRAM enable, a lock request and an open request arrive as inputs from a companion register.

For every processor memory request the decoder examines the address, the SMM-mode flag, the open input and the top-of-memory value. It then picks exactly one route: remap into the legacy SMRAM area, forward to the hub interface, or claim for DRAM. It also produces the address to forward. Requests that touch protected space without privilege are sent to the hub and raise a sticky error bit in the register.

The route outputs and the forwarded address depend combinationally on the request. The error bit and the register fields change on the rising clock edge.

Top module: `smram_guard`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x38.
- R2: Bits 5, 4 and 3 always read as 1, and writes to them have no effect.
- R3: While unlocked, a write stores bit 7 (high-window enable), bits 2:1 (segment size code) and bit 0 (segment enable), and the register reads them back on the next cycle.
- R4: Once the lock input has been high at a clock edge, including the edge of the write itself, bits 7, 2:1 and 0 ignore all writes until reset, even after the lock input falls. Bit 6 stays clearable.
- R5: With the global enable and bit 7 both set, a privileged request (SMM flag or open input high) in 0xFEDA0000–0xFEDBFFFF asserts the remap route, and the forwarded address is 0x000A0000 plus the offset into the window.
- R6: With the global enable and bit 0 set, size code 2'b10 protects [top−0x80000, top) and code 2'b11 protects [top−0x100000, top). A privileged request in that range is claimed for DRAM at its own address.
- R7: A non-privileged request that hits an active high window or an active segment goes to the hub with its address unchanged, and sets bit 6 at the next clock edge.
- R8: With the global enable low, or with segment size code 2'b00 or 2'b01, the corresponding area is inactive. Any request outside an active area is claimed for DRAM when its address is below top-of-memory, and otherwise goes to the hub.
- R9: Bit 6 is sticky. Writing 1 clears it, writing 0 leaves it unchanged, and a set event in the same cycle as a clearing write leaves it set.
- R10: A valid request asserts exactly one of the remap, hub and DRAM routes in the same cycle. With no valid request, none of them is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data |
| cfg_rd_data | output | 8 | Current register contents |
| smram_glb_en | input | 1 | Global SMRAM enable from the companion register |
| smram_lock | input | 1 | Lock request; captured and held until reset |
| smram_open | input | 1 | Grants SMRAM visibility outside SMM |
| req_valid | input | 1 | Processor request present |
| req_addr | input | ADDR_W | Request address |
| req_smm | input | 1 | Request issued in SMM |
| mem_top | input | ADDR_W | Top of DRAM (exclusive) |
| route_remap | output | 1 | Request remapped into the legacy SMRAM area |
| route_hub | output | 1 | Request forwarded to the hub interface |
| route_dram | output | 1 | Request claimed by DRAM |
| route_addr | output | ADDR_W | Address forwarded with the chosen route |

## Verification
The assertions assume that top-of-memory is at least 1 MB and stays constant while a segment is enabled, so the segment base never wraps below zero. They also assume that the high window lies above top-of-memory. The stimulus uses a fixed 256 MB top-of-memory and changes the configuration only by register writes between requests. Request inputs are changed only away from the clock edge, and req_valid is held low whenever the error bit is being cleared for a fresh check.

// File: rtl/smram_pkg.sv
// Package smram_pkg
// Bit positions of the control register and the decoded configuration
// record shared by the register, the window selector and the router.
package smram_pkg;
    localparam int HI_EN_BIT   = 7;
    localparam int ERR_BIT     = 6;
    localparam int SEG_SZ_HI   = 2;
    localparam int SEG_SZ_LO   = 1;
    localparam int SEG_EN_BIT  = 0;
    localparam logic [7:0] RO_ONES   = 8'h38;
    localparam logic [7:0] RESET_VAL = 8'h38;

    typedef struct packed {
        logic       hi_en;
        logic [1:0] seg_sz;
        logic       seg_en;
    } smram_cfg_t;
endpackage

// File: rtl/smram_cfg_reg.sv
// Module smram_cfg_reg
// Holds the lockable fields and the sticky error flag of the control
// register and assembles the read value. Assumes lock_in comes from a
// register that is synchronous to clk.
module smram_cfg_reg
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             lock_in,
    input  logic             err_set,
    output smram_cfg_t       cfg,
    output logic [7:0]       rd_data
);
    smram_cfg_t cfg_q;
    logic       err_q;
    logic       lock_q;
    logic       lock_eff;
    logic       unused_ro_bits;

    assign lock_eff       = lock_q | lock_in;
    assign unused_ro_bits = ^wr_data[5:3];

    // Capture the lock request and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_eff;
    end

    // Update the lockable fields when a write arrives and no lock is in effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{hi_en: RESET_VAL[HI_EN_BIT],
                       seg_sz: RESET_VAL[SEG_SZ_HI:SEG_SZ_LO],
                       seg_en: RESET_VAL[SEG_EN_BIT]};
        end else if (wr_en && !lock_eff) begin
            cfg_q.hi_en  <= wr_data[HI_EN_BIT];
            cfg_q.seg_sz <= wr_data[SEG_SZ_HI:SEG_SZ_LO];
            cfg_q.seg_en <= wr_data[SEG_EN_BIT];
        end
    end

    // Sticky error flag: a set event takes priority over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= RESET_VAL[ERR_BIT];
        else if (err_set)                    err_q <= 1'b1;
        else if (wr_en && wr_data[ERR_BIT])  err_q <= 1'b0;
    end

    // Assemble the read value, with bits 5:3 forced to one.
    always_comb begin
        rd_data                        = RO_ONES;
        rd_data[HI_EN_BIT]             = cfg_q.hi_en;
        rd_data[ERR_BIT]               = err_q;
        rd_data[SEG_SZ_HI:SEG_SZ_LO]   = cfg_q.seg_sz;
        rd_data[SEG_EN_BIT]            = cfg_q.seg_en;
    end

    assign cfg = cfg_q;

    // R2
    ro_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RO_ONES) == RO_ONES);

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_eff |=> $stable(cfg_q));

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_q);

    // R9
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_set && !(wr_en && wr_data[ERR_BIT])) |=> $stable(err_q));

    // R9
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_set && wr_en && wr_data[ERR_BIT]) |=> !err_q);
endmodule

// File: rtl/smram_window_sel.sv
// Module smram_window_sel
// Turns the configuration and the global enable into active flags for the
// high window and the top segment, and computes the segment base below
// top-of-memory. Assumes mem_top is at least the largest segment size.
module smram_window_sel
    import smram_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int SEG_SMALL_LG = 19,
    parameter int SEG_LARGE_LG = 20
) (
    input  smram_cfg_t          cfg,
    input  logic                glb_en,
    input  logic [ADDR_W-1:0]   mem_top,
    output logic                hi_active,
    output logic                seg_active,
    output logic [ADDR_W-1:0]   seg_base
);
    localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] SEG_SMALL = ONE << SEG_SMALL_LG;
    localparam logic [ADDR_W-1:0] SEG_LARGE = ONE << SEG_LARGE_LG;

    logic [ADDR_W-1:0] seg_size;

    // Codes with the upper bit clear are reserved and leave the segment off.
    always_comb begin
        hi_active  = glb_en & cfg.hi_en;
        seg_active = glb_en & cfg.seg_en & cfg.seg_sz[1];
        seg_size   = cfg.seg_sz[0] ? SEG_LARGE : SEG_SMALL;
        seg_base   = mem_top - seg_size;
    end
endmodule

// File: rtl/smram_router.sv
// Module smram_router
// Combinational decode of one request into remap, hub or DRAM, together
// with the forwarded address and the illegal-access event. Assumes the high
// window lies above mem_top and the window base is aligned to its size.
module smram_router #(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_LG   = 17,
    parameter logic [ADDR_W-1:0] HI_BASE  = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0] LOW_BASE = 32'h000A_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_smm,
    input  logic                open_in,
    input  logic                hi_active,
    input  logic                seg_active,
    input  logic [ADDR_W-1:0]   seg_base,
    input  logic [ADDR_W-1:0]   mem_top,
    output logic                route_remap,
    output logic                route_hub,
    output logic                route_dram,
    output logic [ADDR_W-1:0]   route_addr,
    output logic                err_evt
);
    logic priv;
    logic hi_hit;
    logic seg_hit;
    logic below_top;

    // Classify the address against the two protected areas and the DRAM top.
    always_comb begin
        priv      = req_smm | open_in;
        hi_hit    = hi_active &&
                    (req_addr[ADDR_W-1:WIN_LG] == HI_BASE[ADDR_W-1:WIN_LG]);
        below_top = req_addr < mem_top;
        seg_hit   = seg_active && (req_addr >= seg_base) && below_top;
    end

    // Select one route and the forwarded address for a valid request.
    always_comb begin
        route_remap = 1'b0;
        route_hub   = 1'b0;
        route_dram  = 1'b0;
        route_addr  = req_addr;
        err_evt     = 1'b0;
        if (req_valid) begin
            if (hi_hit) begin
                if (priv) begin
                    route_remap = 1'b1;
                    route_addr  = {LOW_BASE[ADDR_W-1:WIN_LG], req_addr[WIN_LG-1:0]};
                end else begin
                    route_hub = 1'b1;
                    err_evt   = 1'b1;
                end
            end else if (seg_hit) begin
                if (priv) begin
                    route_dram = 1'b1;
                end else begin
                    route_hub = 1'b1;
                    err_evt   = 1'b1;
                end
            end else if (below_top) begin
                route_dram = 1'b1;
            end else begin
                route_hub = 1'b1;
            end
        end
    end

    // R10
    onehot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({route_remap, route_hub, route_dram}) == (req_valid ? 1 : 0));

    // R5
    remap_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_remap |-> (req_smm || open_in) && hi_active);

    // R7
    err_hub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> route_hub && !req_smm && !open_in && (route_addr == req_addr));
endmodule

// File: rtl/smram_guard.sv
// Module smram_guard
// Top level: the SMRAM control register plus the request decoder it steers.
// Assumes mem_top is at least 1 MB and changes only while the segment is off.
module smram_guard
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [7:0]          cfg_wr_data,
    output logic [7:0]          cfg_rd_data,
    input  logic                smram_glb_en,
    input  logic                smram_lock,
    input  logic                smram_open,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_smm,
    input  logic [ADDR_W-1:0]   mem_top,
    output logic                route_remap,
    output logic                route_hub,
    output logic                route_dram,
    output logic [ADDR_W-1:0]   route_addr
);
    smram_cfg_t        cfg;
    logic              hi_active;
    logic              seg_active;
    logic [ADDR_W-1:0] seg_base;
    logic              err_evt;

    smram_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .lock_in (smram_lock),
        .err_set (err_evt),
        .cfg     (cfg),
        .rd_data (cfg_rd_data)
    );

    smram_window_sel #(.ADDR_W(ADDR_W)) u_win (
        .cfg        (cfg),
        .glb_en     (smram_glb_en),
        .mem_top    (mem_top),
        .hi_active  (hi_active),
        .seg_active (seg_active),
        .seg_base   (seg_base)
    );

    smram_router #(.ADDR_W(ADDR_W)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_smm     (req_smm),
        .open_in     (smram_open),
        .hi_active   (hi_active),
        .seg_active  (seg_active),
        .seg_base    (seg_base),
        .mem_top     (mem_top),
        .route_remap (route_remap),
        .route_hub   (route_hub),
        .route_dram  (route_dram),
        .route_addr  (route_addr),
        .err_evt     (err_evt)
    );
endmodule

// File: tb/tb_smram_guard.sv
// Bench for smram_guard: a table of requests under one fixed configuration,
// then directed tests for reset, locking, reserved codes and the error flag.
module tb_smram_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic [7:0]  cfg_rd_data;
    logic        smram_glb_en = 1'b0;
    logic        smram_lock = 1'b0;
    logic        smram_open = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        req_smm = 1'b0;
    logic [31:0] mem_top = 32'h1000_0000;
    logic        route_remap, route_hub, route_dram;
    logic [31:0] route_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    smram_guard dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .smram_glb_en(smram_glb_en), .smram_lock(smram_lock), .smram_open(smram_open),
        .req_valid(req_valid), .req_addr(req_addr), .req_smm(req_smm), .mem_top(mem_top),
        .route_remap(route_remap), .route_hub(route_hub), .route_dram(route_dram),
        .route_addr(route_addr)
    );

    // Route codes: 3'b100 remap, 3'b010 hub, 3'b001 DRAM.
    localparam logic [2:0] RM = 3'b100, HB = 3'b010, DR = 3'b001;
    // Entry: {addr, smm, open, route, fwd addr, error}; config H=1, size 11, seg on.
    localparam int NV = 13;
    localparam logic [69:0] VEC [NV] = '{
        {32'h0000_1000, 1'b0, 1'b0, DR, 32'h0000_1000, 1'b0},
        {32'hFEDA_0000, 1'b1, 1'b0, RM, 32'h000A_0000, 1'b0},
        {32'hFEDB_FFFF, 1'b1, 1'b0, RM, 32'h000B_FFFF, 1'b0},
        {32'hFEDC_0000, 1'b1, 1'b0, HB, 32'hFEDC_0000, 1'b0},
        {32'hFED9_FFFC, 1'b1, 1'b0, HB, 32'hFED9_FFFC, 1'b0},
        {32'hFEDA_1234, 1'b0, 1'b0, HB, 32'hFEDA_1234, 1'b1},
        {32'hFEDA_1234, 1'b0, 1'b1, RM, 32'h000A_1234, 1'b0},
        {32'h0FF0_0000, 1'b1, 1'b0, DR, 32'h0FF0_0000, 1'b0},
        {32'h0FEF_FFFF, 1'b0, 1'b0, DR, 32'h0FEF_FFFF, 1'b0},
        {32'h0FF0_0000, 1'b0, 1'b0, HB, 32'h0FF0_0000, 1'b1},
        {32'h0FFF_FFFF, 1'b0, 1'b0, HB, 32'h0FFF_FFFF, 1'b1},
        {32'h1000_0000, 1'b0, 1'b0, HB, 32'h1000_0000, 1'b0},
        {32'h0FF8_0000, 1'b0, 1'b1, DR, 32'h0FF8_0000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic apply_req(input string req, input logic [31:0] a, input logic smm,
                             input logic opn, input logic [2:0] er,
                             input logic [31:0] ea, input logic ee);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_smm = smm; smram_open = opn;
        #2;
        check(req, {29'd0, route_remap, route_hub, route_dram}, {29'd0, er});
        check(req, route_addr, ea);
        @(negedge clk);
        req_valid = 1'b0; req_smm = 1'b0; smram_open = 1'b0;
        check(req, {31'd0, cfg_rd_data[6]}, {31'd0, ee});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value, R10 no route while idle
        check("R1", {24'd0, cfg_rd_data}, 32'h38);
        check("R10", {29'd0, route_remap, route_hub, route_dram}, 32'd0);

        // R2 read-only ones survive a write of zero
        do_write(8'h00);
        check("R2", {24'd0, cfg_rd_data}, 32'h38);
        // R3 lockable fields store their values
        do_write(8'h87);
        check("R3", {24'd0, cfg_rd_data}, 32'hBF);

        // R8 global enable low disables both areas
        apply_req("R8", 32'hFEDA_0000, 1'b1, 1'b0, HB, 32'hFEDA_0000, 1'b0);
        apply_req("R8", 32'h0FFF_0000, 1'b0, 1'b0, DR, 32'h0FFF_0000, 1'b0);
        smram_glb_en = 1'b1;

        // R5 R6 R7 R8 R10 table walk
        do_write(8'hC7);
        check("R3", {24'd0, cfg_rd_data}, 32'hBF);
        for (int i = 0; i < NV; i++) begin
            apply_req("R5_R6_R7_R8_R10", VEC[i][69:38], VEC[i][37], VEC[i][36],
                      VEC[i][35:33], VEC[i][32:1], VEC[i][0]);
            do_write(8'hC7);
        end

        // R8 reserved size code leaves the segment inactive
        do_write(8'h83);
        apply_req("R8", 32'h0FF0_0000, 1'b0, 1'b0, DR, 32'h0FF0_0000, 1'b0);
        do_write(8'h81);
        apply_req("R8", 32'h0FFF_FFF0, 1'b0, 1'b0, DR, 32'h0FFF_FFF0, 1'b0);

        // R6 size code 10 covers only the upper 512 KB
        do_write(8'h85);
        apply_req("R6", 32'h0FF7_FFFF, 1'b0, 1'b0, DR, 32'h0FF7_FFFF, 1'b0);
        apply_req("R6", 32'h0FF8_0000, 1'b1, 1'b0, DR, 32'h0FF8_0000, 1'b0);
        apply_req("R7", 32'h0FF8_0000, 1'b0, 1'b0, HB, 32'h0FF8_0000, 1'b1);

        // R9 write of zero keeps the flag, set beats clear, write one clears
        do_write(8'h85);
        check("R9", {31'd0, cfg_rd_data[6]}, 32'd1);
        do_write(8'hC5);
        check("R9", {31'd0, cfg_rd_data[6]}, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0FFC_0000; req_smm = 1'b0;
        cfg_wr_en = 1'b1; cfg_wr_data = 8'hC5;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        check("R9", {31'd0, cfg_rd_data[6]}, 32'd1);
        do_write(8'hC5);
        check("R9", {24'd0, cfg_rd_data}, 32'hBD);

        // R4 lock in the same cycle as a write blocks it, and stays after release
        @(negedge clk);
        smram_lock = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 8'h02;
        @(negedge clk);
        smram_lock = 1'b0; cfg_wr_en = 1'b0;
        check("R4", {24'd0, cfg_rd_data}, 32'hBD);
        do_write(8'h07);
        check("R4", {24'd0, cfg_rd_data}, 32'hBD);
        apply_req("R4", 32'h0FF9_0000, 1'b0, 1'b0, HB, 32'h0FF9_0000, 1'b1);
        do_write(8'h40);
        check("R4", {24'd0, cfg_rd_data}, 32'hBD);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule